// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller with User Data Register Hooks

This block is the serial test port for a chip that follows the IEEE 1149.1 test access protocol. It steps the sixteen-state port sequencer on each rising test clock, guided by the mode-select input. It also holds a three-bit instruction register and decodes the loaded instruction. The only data register it contains is a one-bit bypass stage. The boundary register lives outside the block, so the controller gives it capture, shift and update strobes and takes its serial return.

Two user instructions hand the scan path to data registers built in core logic. For each one the controller raises a select line, routes that instruction's serial return to the test data output, and supplies a gated data-register clock that runs only during capture and shift of a user data register. An active-low idle output equals the NAND of the test clock and the run-test/idle state, so core logic can time its own actions to idle clocks. The reset input `trst` is synchronous and active high.

Top module: `scan_port_ctrl`

## Requirements
- R1: The sequencer follows the standard sixteen-state test port graph and moves on each rising `tck` as selected by `tms`. Five rising edges with `tms` high reach test-logic-reset from any state, and a following low `tms` enters run-test/idle.
- R2: `trst` high at a rising `tck` forces test-logic-reset. At the next falling edge the current instruction becomes bypass, so both user selects and all boundary strobes are low.
- R3: Capture-IR loads binary 001 into the instruction shift stage. During Shift-IR the stage shifts toward its least significant bit, which is presented on `tdo`, and `tdi` enters at the most significant bit.
- R4: A shifted instruction becomes current at the falling `tck` in Update-IR. The codes are 000 external test, 001 sample, 010 user one, 011 user two and 111 bypass. The unused codes 100, 101 and 110 act exactly as bypass.
- R5: Under bypass, Capture-DR clears the one-bit stage. Shift-DR then presents that 0 first and afterwards each `tdi` bit delayed by one clock.
- R6: `usr1_sel` is high exactly while code 010 is current, and `usr2_sel` is high exactly while code 011 is current.
- R7: In Shift-DR under a user instruction, `tdo` carries the matching user return input sampled at the falling `tck`.
- R8: `tdo` and `tdo_en` change only on falling `tck`. `tdo_en` is high only in Shift-IR or Shift-DR, and `tdo` is 0 outside those two states.
- R9: `dr_clk` follows `tck` only for the clock periods that begin in Capture-DR or Shift-DR under a user instruction. Otherwise it stays low.
- R10: `idle_n` is the NAND of `tck` and the run-test/idle state.
- R11: `bnd_capture`, `bnd_shift` and `bnd_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and only while code 000 or 001 is current.
- R12: In Shift-DR under code 000 or 001, `tdo` carries `bnd_ret` sampled at the falling `tck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high port reset |
| tms | input | 1 | Mode select that steers the sequencer |
| tdi | input | 1 | Serial test data in |
| usr1_ret | input | 1 | Serial return of user data register one |
| usr2_ret | input | 1 | Serial return of user data register two |
| bnd_ret | input | 1 | Serial return of the external boundary register |
| tdo | output | 1 | Serial test data out, updated on falling clock |
| tdo_en | output | 1 | Output enable for `tdo` |
| usr1_sel | output | 1 | User instruction one is current |
| usr2_sel | output | 1 | User instruction two is current |
| dr_clk | output | 1 | Gated data-register clock for user registers |
| idle_n | output | 1 | NAND of `tck` and run-test/idle |
| bnd_capture | output | 1 | Boundary register capture strobe |
| bnd_shift | output | 1 | Boundary register shift strobe |
| bnd_update | output | 1 | Boundary register update strobe |

## Verification
The sequencer state and the boundary strobes move on the rising edge, so they are due in the high half of that same clock period. The selects, `tdo`, `tdo_en` and the `dr_clk` gate move one half period later, on the falling edge. `idle_n` and `dr_clk` also follow the level of `tck` itself. The bench drives every input in the middle of the low phase. A behavioural model updates at each edge, and all outputs are compared in the middle of both the high and the low phase, so each result is checked in the half period where it is due and never at an edge.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        OP_EXTEST, OP_SAMPLE, OP_USER1, OP_USER2, OP_BYPASS
    } tap_op_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } bnd_strobe_t;

    localparam logic [IR_W-1:0] CODE_EXTEST = 3'b000;
    localparam logic [IR_W-1:0] CODE_SAMPLE = 3'b001;
    localparam logic [IR_W-1:0] CODE_USER1  = 3'b010;
    localparam logic [IR_W-1:0] CODE_USER2  = 3'b011;
    localparam logic [IR_W-1:0] CODE_BYPASS = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic tap_op_e op_decode(logic [IR_W-1:0] code);
        tap_op_e op;
        case (code)
            CODE_EXTEST: op = OP_EXTEST;
            CODE_SAMPLE: op = OP_SAMPLE;
            CODE_USER1:  op = OP_USER1;
            CODE_USER2:  op = OP_USER2;
            default:     op = OP_BYPASS;
        endcase
        return op;
    endfunction

    function automatic logic op_is_user(tap_op_e op);
        return (op == OP_USER1) || (op == OP_USER2);
    endfunction

    function automatic logic op_is_boundary(tap_op_e op);
        return (op == OP_EXTEST) || (op == OP_SAMPLE);
    endfunction

endpackage

// File: rtl/tap_seq.sv
module tap_seq
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_e state_q
);

    always_ff @(posedge tck) begin
        if (trst) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= tap_next(state_q, tms);
        end
    end

endmodule

// File: rtl/tap_instr.sv
module tap_instr
    import scan_pkg::*;
#(
    parameter int W = scan_pkg::IR_W
) (
    input  logic         tck,
    input  logic         trst,
    input  logic         tdi,
    input  tap_state_e   state,
    output logic [W-1:0] ir_sr,
    output logic [W-1:0] ir_cur,
    output tap_op_e      op
);

    always_ff @(posedge tck) begin
        if (trst) begin
            ir_sr <= '0;
        end else if (state == ST_CAP_IR) begin
            ir_sr <= IR_CAPTURE;
        end else if (state == ST_SHF_IR) begin
            ir_sr <= {tdi, ir_sr[W-1:1]};
        end
    end

    always_ff @(negedge tck) begin
        if (trst || state == ST_RESET) begin
            ir_cur <= CODE_BYPASS;
        end else if (state == ST_UPD_IR) begin
            ir_cur <= ir_sr;
        end
    end

    assign op = op_decode(ir_cur);

endmodule

// File: rtl/tap_dr_path.sv
module tap_dr_path
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tdi,
    input  tap_state_e state,
    input  tap_op_e    op,
    input  logic       ir_lsb,
    input  logic       usr1_ret,
    input  logic       usr2_ret,
    input  logic       bnd_ret,
    output logic       byp_q,
    output logic       tdo,
    output logic       tdo_en,
    output logic       dr_clk
);

    logic out_bit;
    logic shifting;
    logic gate_q;

    always_ff @(posedge tck) begin
        if (trst) begin
            byp_q <= 1'b0;
        end else if (state == ST_CAP_DR) begin
            byp_q <= 1'b0;
        end else if (state == ST_SHF_DR) begin
            byp_q <= tdi;
        end
    end

    always_comb begin
        out_bit = 1'b0;
        if (state == ST_SHF_IR) begin
            out_bit = ir_lsb;
        end else if (state == ST_SHF_DR) begin
            case (op)
                OP_USER1:  out_bit = usr1_ret;
                OP_USER2:  out_bit = usr2_ret;
                OP_BYPASS: out_bit = byp_q;
                default:   out_bit = bnd_ret;
            endcase
        end
    end

    assign shifting = (state == ST_SHF_IR) || (state == ST_SHF_DR);

    always_ff @(negedge tck) begin
        if (trst || state == ST_RESET) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            tdo    <= out_bit;
            tdo_en <= shifting;
            gate_q <= ((state == ST_CAP_DR) || (state == ST_SHF_DR)) && op_is_user(op);
        end
    end

    assign dr_clk = tck & gate_q;

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_pkg::*;
#(
    parameter int IR_BITS = scan_pkg::IR_W
) (
    input  logic tck,
    input  logic trst,
    input  logic tms,
    input  logic tdi,
    input  logic usr1_ret,
    input  logic usr2_ret,
    input  logic bnd_ret,
    output logic tdo,
    output logic tdo_en,
    output logic usr1_sel,
    output logic usr2_sel,
    output logic dr_clk,
    output logic idle_n,
    output logic bnd_capture,
    output logic bnd_shift,
    output logic bnd_update
);

    tap_state_e         state_q;
    tap_op_e            op;
    logic [IR_BITS-1:0] ir_sr;
    logic [IR_BITS-1:0] ir_cur;
    logic               byp_q;
    bnd_strobe_t        strobe;

    tap_seq u_seq (
        .tck     (tck),
        .trst    (trst),
        .tms     (tms),
        .state_q (state_q)
    );

    tap_instr #(.W(IR_BITS)) u_instr (
        .tck    (tck),
        .trst   (trst),
        .tdi    (tdi),
        .state  (state_q),
        .ir_sr  (ir_sr),
        .ir_cur (ir_cur),
        .op     (op)
    );

    tap_dr_path u_dr (
        .tck      (tck),
        .trst     (trst),
        .tdi      (tdi),
        .state    (state_q),
        .op       (op),
        .ir_lsb   (ir_sr[0]),
        .usr1_ret (usr1_ret),
        .usr2_ret (usr2_ret),
        .bnd_ret  (bnd_ret),
        .byp_q    (byp_q),
        .tdo      (tdo),
        .tdo_en   (tdo_en),
        .dr_clk   (dr_clk)
    );

    always_comb begin
        strobe.capture = op_is_boundary(op) && (state_q == ST_CAP_DR);
        strobe.shift   = op_is_boundary(op) && (state_q == ST_SHF_DR);
        strobe.update  = op_is_boundary(op) && (state_q == ST_UPD_DR);
    end

    assign bnd_capture = strobe.capture;
    assign bnd_shift   = strobe.shift;
    assign bnd_update  = strobe.update;
    assign usr1_sel    = (op == OP_USER1);
    assign usr2_sel    = (op == OP_USER2);
    assign idle_n      = ~(tck & (state_q == ST_IDLE));

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
    import scan_pkg::*;
(
    input logic       tck,
    input logic       trst,
    input logic       tdi,
    input tap_state_e state_q,
    input logic [2:0] ir_sr,
    input logic [2:0] ir_cur,
    input tap_op_e    op,
    input logic       byp_q,
    input logic       tdo_en,
    input logic       dr_clk,
    input logic       idle_n,
    input logic       usr1_sel,
    input logic       usr2_sel,
    input logic       bnd_update
);

    // R2
    reset_entry_chk: assert property (@(posedge tck)
        trst |=> (state_q == ST_RESET));

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (trst)
        (state_q == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE));

    // R4
    ir_update_chk: assert property (@(negedge tck) disable iff (trst)
        (state_q == ST_UPD_IR) |=> (ir_cur == $past(ir_sr)));

    // R5
    bypass_delay_chk: assert property (@(posedge tck) disable iff (trst)
        (state_q == ST_SHF_DR && op == OP_BYPASS) |=> (byp_q == $past(tdi)));

    // R6
    user_sel_excl_chk: assert property (@(posedge tck) disable iff (trst)
        $onehot0({usr1_sel, usr2_sel}));

    // R8
    tdo_en_state_chk: assert property (@(posedge tck) disable iff (trst)
        tdo_en |-> (state_q == ST_SHF_IR || state_q == ST_SHF_DR));

    // R9
    dr_clk_user_chk: assert property (@(negedge tck) disable iff (trst)
        dr_clk |-> (usr1_sel || usr2_sel));

    // R10
    idle_low_chk: assert property (@(negedge tck) disable iff (trst)
        (state_q == ST_IDLE) |-> !idle_n);

    // R11
    bnd_not_user_chk: assert property (@(posedge tck) disable iff (trst)
        bnd_update |-> !(usr1_sel || usr2_sel));

endmodule

bind scan_port_ctrl scan_port_chk u_chk (
    .tck        (tck),
    .trst       (trst),
    .tdi        (tdi),
    .state_q    (state_q),
    .ir_sr      (ir_sr),
    .ir_cur     (ir_cur),
    .op         (op),
    .byp_q      (byp_q),
    .tdo_en     (tdo_en),
    .dr_clk     (dr_clk),
    .idle_n     (idle_n),
    .usr1_sel   (usr1_sel),
    .usr2_sel   (usr2_sel),
    .bnd_update (bnd_update)
);

// File: tb/sim_scan_port_ctrl.sv
`timescale 1ns/1ps
module sim_scan_port_ctrl;

    logic tck = 1'b0, trst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic usr1_ret = 1'b0, usr2_ret = 1'b0, bnd_ret = 1'b0;
    logic tdo, tdo_en, usr1_sel, usr2_sel, dr_clk, idle_n;
    logic bnd_capture, bnd_shift, bnd_update;

    scan_port_ctrl u0 (
        .tck(tck), .trst(trst), .tms(tms), .tdi(tdi),
        .usr1_ret(usr1_ret), .usr2_ret(usr2_ret), .bnd_ret(bnd_ret),
        .tdo(tdo), .tdo_en(tdo_en), .usr1_sel(usr1_sel), .usr2_sel(usr2_sel),
        .dr_clk(dr_clk), .idle_n(idle_n),
        .bnd_capture(bnd_capture), .bnd_shift(bnd_shift), .bnd_update(bnd_update)
    );

    // model state numbering, independent of the design
    localparam int M_TLR = 0,  M_RTI = 1,  M_SDR = 2,  M_CDR = 3,  M_SHD = 4,
                   M_E1D = 5,  M_PD  = 6,  M_E2D = 7,  M_UD  = 8,  M_SIR = 9,
                   M_CIR = 10, M_SHI = 11, M_E1I = 12, M_PI  = 13, M_E2I = 14, M_UI = 15;

    int nx [16][2];
    int m_st = M_TLR;
    int m_irsr = 0, m_ir = 7, m_byp = 0, m_tdo = 0, m_en = 0, m_dren = 0;
    string m_tag = "R8";
    int n_cmp = 0, n_bad = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    logic last_idle_hi = 1'b1;

    initial begin
        nx[M_TLR] = '{M_RTI, M_TLR}; nx[M_RTI] = '{M_RTI, M_SDR};
        nx[M_SDR] = '{M_CDR, M_SIR}; nx[M_CDR] = '{M_SHD, M_E1D};
        nx[M_SHD] = '{M_SHD, M_E1D}; nx[M_E1D] = '{M_PD,  M_UD};
        nx[M_PD]  = '{M_PD,  M_E2D}; nx[M_E2D] = '{M_SHD, M_UD};
        nx[M_UD]  = '{M_RTI, M_SDR}; nx[M_SIR] = '{M_CIR, M_TLR};
        nx[M_CIR] = '{M_SHI, M_E1I}; nx[M_SHI] = '{M_SHI, M_E1I};
        nx[M_E1I] = '{M_PI,  M_UI};  nx[M_PI]  = '{M_PI,  M_E2I};
        nx[M_E2I] = '{M_SHI, M_UI};  nx[M_UI]  = '{M_RTI, M_SDR};
    end

    // 0 extest, 1 sample, 2 user one, 3 user two, 4 bypass (R4 codes)
    function automatic int m_op(int code);
        if (code == 0) return 0;
        if (code == 1) return 1;
        if (code == 2) return 2;
        if (code == 3) return 3;
        return 4;
    endfunction

    task automatic model_rise();
        if (trst) begin
            m_st = M_TLR; m_irsr = 0; m_byp = 0;
        end else begin
            if (m_st == M_CIR) m_irsr = 1;
            else if (m_st == M_SHI) m_irsr = (int'(tdi) << 2) | (m_irsr >> 1);
            else if (m_st == M_CDR) m_byp = 0;
            else if (m_st == M_SHD) m_byp = int'(tdi);
            m_st = nx[m_st][int'(tms)];
        end
    endtask

    task automatic model_fall();
        int op;
        if (trst || m_st == M_TLR) begin
            m_tdo = 0; m_en = 0; m_dren = 0; m_ir = 7; m_tag = "R8";
        end else begin
            op = m_op(m_ir);
            m_en = (m_st == M_SHI || m_st == M_SHD) ? 1 : 0;
            m_dren = ((m_st == M_CDR || m_st == M_SHD) && (op == 2 || op == 3)) ? 1 : 0;
            if (m_st == M_SHI) begin
                m_tdo = m_irsr & 1; m_tag = "R3";
            end else if (m_st == M_SHD) begin
                if (op == 2)      begin m_tdo = int'(usr1_ret); m_tag = "R7";  end
                else if (op == 3) begin m_tdo = int'(usr2_ret); m_tag = "R7";  end
                else if (op == 4) begin m_tdo = m_byp;          m_tag = "R5";  end
                else              begin m_tdo = int'(bnd_ret);  m_tag = "R12"; end
            end else begin
                m_tdo = 0; m_tag = "R8";
            end
            if (m_st == M_UI) m_ir = m_irsr;
        end
    endtask

    task automatic cmp(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input bit hi);
        int op;
        op = m_op(m_ir);
        if (hi) last_idle_hi = idle_n;
        if (!chk_on) return;
        cmp(m_tag, "tdo", tdo, 1'(m_tdo));
        cmp("R8", "tdo_en", tdo_en, 1'(m_en));
        cmp("R6", "usr1_sel", usr1_sel, op == 2);
        cmp("R6", "usr2_sel", usr2_sel, op == 3);
        cmp("R9", "dr_clk", dr_clk, hi && m_dren != 0);
        cmp("R10", "idle_n", idle_n, !(hi && m_st == M_RTI));
        cmp("R11", "bnd_capture", bnd_capture, (op < 2) && m_st == M_CDR);
        cmp("R11", "bnd_shift", bnd_shift, (op < 2) && m_st == M_SHD);
        cmp("R11", "bnd_update", bnd_update, (op < 2) && m_st == M_UD);
    endtask

    task automatic tick(input logic t_ms, input logic t_di);
        tms = t_ms; tdi = t_di;
        usr1_ret = 1'($urandom); usr2_ret = 1'($urandom); bnd_ret = 1'($urandom);
        #5 tck = 1'b1; model_rise();
        #5 compare_all(1'b1);
        #5 tck = 1'b0; model_fall();
        #5 compare_all(1'b0);
    endtask

    // from run-test/idle: load a code, return to run-test/idle
    task automatic load_ir(input logic [2:0] code);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        tick(0, code[0]); tick(0, code[1]); tick(1, code[2]);
        tick(1, 0); tick(0, 0);
    endtask

    task automatic shift_dr(input int n);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) tick(i == n - 1, 1'($urandom));
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        trst = 1'b1;
        tick(1, 0);
        chk_on = 1'b1;
        tick(1, 0);                       // R2 reset state compared here
        trst = 1'b0;
        cmp("R2", "usr sel after reset", usr1_sel | usr2_sel, 1'b0);
        tick(0, 0); tick(0, 0);           // enter idle (R10)

        load_ir(3'b111); shift_dr(8);     // R5 bypass
        load_ir(3'b010); shift_dr(6);     // R7, R9 user one
        cmp("R6", "usr1 after load", usr1_sel, 1'b1);
        load_ir(3'b011); shift_dr(6);     // R7 user two
        load_ir(3'b000); shift_dr(5);     // R11, R12 external test
        load_ir(3'b001); shift_dr(5);     // R11 sample
        load_ir(3'b101); shift_dr(6);     // R4 unused code as bypass
        cmp("R4", "no select for unused code", usr1_sel | usr2_sel, 1'b0);
        load_ir(3'b100); shift_dr(4);     // R4
        load_ir(3'b110); shift_dr(4);     // R4
        load_ir(3'b010);
        trst = 1'b1; tick(0, 0); trst = 1'b0;
        cmp("R2", "usr1 cleared by trst", usr1_sel, 1'b0);

        for (int i = 0; i < 3000; i++) begin
            trst = ($urandom % 400 == 0);
            tick(($urandom % 3) == 0, 1'($urandom));
        end
        trst = 1'b0;
        for (int i = 0; i < 5; i++) tick(1, 0);
        tick(0, 0);
        cmp("R1", "idle_n in idle after five ones", last_idle_hi, 1'b0);
        cmp("R1", "bypass after five ones", usr1_sel | usr2_sel, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule